// File: doc/BRIEF.md
# Power-up reset sequencer with configuration decode

This block keeps a small processor core in reset after power is applied. It releases the core only once a power-up delay and an oscillator start-up count have both run out. A 14-bit configuration word controls it. The bits of that word are active-low in spirit: a programmed bit reads 0 and an erased bit reads 1. Fields of the word decide whether the power-up delay is used and whether the external master-clear pin can force a reset. The oscillator field decides whether the core waits for a crystal to settle.

The same word is decoded into steady outputs: the watchdog enable, the oscillator family and clock-out choice, and the code-protection region. The delay is counted in strobes of a free-running timebase, and the parameter `PWRT_TICKS` gives the number of strobes for the nominal 72 ms. The start-up count is counted in oscillator clock cycles. Every part of the block runs on the oscillator clock. The timebase arrives as a one-cycle enable, `tick_i`.

Top module: `por_cfg_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is high. It stays high for at least the first clock edge after `por_i` falls.
- R2: The power-up delay runs only after a power-on event. Leaving a master-clear hold never reruns it.
- R3: If bit 4 of `cfg_i` is 0, the core stays in reset after power-on until `PWRT_TICKS` cycles with `tick_i` high have been seen. If bit 4 is 1, this delay is skipped.
- R4: When bits 2:0 select a crystal mode (000 LP, 001 XT, 010 HS), reset is held for a further `OST_CYCLES` clock cycles after the power-up delay, or after a master-clear release. RC codes and the invalid code skip this count.
- R5: If bit 7 is 1, a low `mclr_n_i` sets `core_rst_o` from the next edge on and holds it there while the pin stays low.
- R6: If bit 7 is 0, `mclr_n_i` has no effect on `core_rst_o`.
- R7: The oscillator field is decoded as follows. `osc_xtal_o` is one-hot: bit 0 for LP, bit 1 for XT, bit 2 for HS. `osc_int_rc_o` is set for 100 and 101. `osc_ext_rc_o` is set for 110 and 111. `osc_err_o` is set only for 011, which is otherwise handled like an RC mode.
- R8: `clkout_en_o` is 1 for codes 101 and 111 only.
- R9: The protection pairs sit at bits 13:12, 11:10, 9:8 and 6:5. When all four are equal, `prot_o` = 0 for pair 11 (off), 1 for pair 10 (400h–7FEh), 2 for pair 01 (200h–7FEh) and 3 for pair 00 (all). When they are not all equal, `cp_mismatch_o` = 1 and `prot_o` = 0.
- R10: `wdt_en_o` equals bit 3 of `cfg_i` (1 = watchdog on). No other input affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on reset pulse, active high |
| mclr_n_i | input | 1 | External master-clear pin, active low |
| tick_i | input | 1 | One-cycle timebase strobe |
| cfg_i | input | 14 | Configuration word |
| core_rst_o | output | 1 | Core reset, active high |
| wdt_en_o | output | 1 | Watchdog enable |
| osc_xtal_o | output | 3 | One-hot crystal mode {HS, XT, LP} |
| osc_int_rc_o | output | 1 | Internal RC mode |
| osc_ext_rc_o | output | 1 | External RC mode |
| clkout_en_o | output | 1 | Second oscillator pin drives clock out |
| osc_err_o | output | 1 | Invalid oscillator code |
| prot_o | output | 2 | Protected region level |
| cp_mismatch_o | output | 1 | Protection pairs disagree |

## Verification
A wrong sequencer state or counter value shows up as `core_rst_o` falling early or late. The edge at which the reset is released is predicted from the tick pattern and the configuration, so a miscount of one strobe or one clock is seen on the first cycle that differs. Decode faults appear on the outputs in the same cycle, because those outputs are purely combinational. A stuck master-clear path shows within one edge of the pin going low.

// File: rtl/por_cfg_seq.sv
module por_cfg_seq #(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024
) (
  input  logic        clk_i,
  input  logic        por_i,
  input  logic        mclr_n_i,
  input  logic        tick_i,
  input  logic [13:0] cfg_i,
  output logic        core_rst_o,
  output logic        wdt_en_o,
  output logic [2:0]  osc_xtal_o,
  output logic        osc_int_rc_o,
  output logic        osc_ext_rc_o,
  output logic        clkout_en_o,
  output logic        osc_err_o,
  output logic [1:0]  prot_o,
  output logic        cp_mismatch_o
);
  localparam int MAXC = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_TICKS - 1);
  localparam logic [CW-1:0] OST_LAST = CW'(OST_CYCLES - 1);

  typedef enum logic [2:0] {S_POR, S_PWRT, S_OST, S_MCLR, S_RUN} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  wire [2:0] fosc = cfg_i[2:0];
  wire pwrt_on = ~cfg_i[4];
  wire mclr_on = cfg_i[7];
  wire xtal = ~fosc[2] & ~(fosc[1] & fosc[0]);
  wire mclr_hit = mclr_on & ~mclr_n_i;
  wire st_t after_pwrt = xtal ? S_OST : S_RUN;

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      st <= S_POR;
      cnt <= '0;
    end else if (mclr_hit) begin
      st <= S_MCLR;
      cnt <= '0;
    end else begin
      case (st)
        S_POR: begin
          st <= pwrt_on ? S_PWRT : after_pwrt;
          cnt <= '0;
        end
        S_PWRT: if (tick_i) begin
          if (cnt == PWRT_LAST) begin
            st <= after_pwrt;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_OST: begin
          if (cnt == OST_LAST) begin
            st <= S_RUN;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_MCLR: begin
          st <= after_pwrt;
          cnt <= '0;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign core_rst_o = (st != S_RUN);
  assign wdt_en_o = cfg_i[3];

  assign osc_xtal_o[0] = (fosc == 3'b000);
  assign osc_xtal_o[1] = (fosc == 3'b001);
  assign osc_xtal_o[2] = (fosc == 3'b010);
  assign osc_err_o = (fosc == 3'b011);
  assign osc_int_rc_o = (fosc[2:1] == 2'b10);
  assign osc_ext_rc_o = (fosc[2:1] == 2'b11);
  assign clkout_en_o = fosc[2] & fosc[0];

  wire [1:0] pa = cfg_i[13:12];
  wire [1:0] pb = cfg_i[11:10];
  wire [1:0] pc = cfg_i[9:8];
  wire [1:0] pd = cfg_i[6:5];
  wire pairs_eq = (pa == pb) && (pb == pc) && (pc == pd);
  assign cp_mismatch_o = ~pairs_eq;
  assign prot_o = pairs_eq ? ~pd : 2'b00;

  AST_POR_HOLD: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(por_i) |-> core_rst_o); // R1
  AST_PWRT_FROM_POR: assert property (@(posedge clk_i) disable iff (por_i)
    (st == S_PWRT) |-> ($past(st) == S_POR || $past(st) == S_PWRT)); // R2
  AST_PWRT_ONLY_IF_ON: assert property (@(posedge clk_i) disable iff (por_i)
    ($past(st) == S_POR && st == S_PWRT) |-> $past(pwrt_on)); // R3
  AST_OST_XTAL_ONLY: assert property (@(posedge clk_i) disable iff (por_i)
    ($past(st) != S_OST && st == S_OST) |-> $past(xtal)); // R4
  AST_MCLR_RESETS: assert property (@(posedge clk_i) disable iff (por_i)
    mclr_hit |=> core_rst_o); // R5
  AST_MCLR_IGNORED: assert property (@(posedge clk_i) disable iff (por_i)
    (!core_rst_o && !mclr_on) |=> !core_rst_o); // R6
  AST_OSC_ONEHOT: assert property (@(posedge clk_i)
    $onehot({osc_xtal_o, osc_int_rc_o, osc_ext_rc_o, osc_err_o})); // R7
endmodule

// File: tb/tb_por_cfg_seq.sv
module tb_por_cfg_seq;
  localparam int PT = 5;
  localparam int OC = 16;

  logic clk = 0;
  logic por, mclr_n, tick;
  logic [13:0] cfg;
  logic core_rst, wdt_en, int_rc, ext_rc, clkout, oerr, mism;
  logic [2:0] xt;
  logic [1:0] prot;

  always #4 clk = ~clk;

  por_cfg_seq #(.PWRT_TICKS(PT), .OST_CYCLES(OC)) dut (
    .clk_i(clk), .por_i(por), .mclr_n_i(mclr_n), .tick_i(tick), .cfg_i(cfg),
    .core_rst_o(core_rst), .wdt_en_o(wdt_en), .osc_xtal_o(xt),
    .osc_int_rc_o(int_rc), .osc_ext_rc_o(ext_rc), .clkout_en_o(clkout),
    .osc_err_o(oerr), .prot_o(prot), .cp_mismatch_o(mism));

  int n_chk = 0, n_bad = 0;
  int ph = 0;
  int rem = 0;
  bit done = 0;

  function automatic bit is_xtal(logic [13:0] c);
    return c[2:0] == 3'd0 || c[2:0] == 3'd1 || c[2:0] == 3'd2;
  endfunction

  function automatic logic [8:0] exp_osc(logic [13:0] c);
    logic [2:0] f = c[2:0];
    return {f == 3'd2, f == 3'd1, f == 3'd0, f == 3'd4 || f == 3'd5,
            f == 3'd6 || f == 3'd7, f == 3'd5 || f == 3'd7, f == 3'd3, 2'b00};
  endfunction

  function automatic logic [2:0] exp_prot(logic [13:0] c);
    if (c[13:12] == c[11:10] && c[11:10] == c[9:8] && c[9:8] == c[6:5])
      case (c[6:5])
        2'b11: return 3'b000;
        2'b10: return 3'b001;
        2'b01: return 3'b010;
        default: return 3'b011;
      endcase
    return 3'b100;
  endfunction

  // reference phases: 0 por, 1 pwrt, 2 ost, 3 mclr, 4 run
  always @(posedge clk) begin
    if (por) ph = 0;
    else if (cfg[7] && !mclr_n) ph = 3;
    else case (ph)
      0: if (!cfg[4]) begin ph = 1; rem = PT; end
         else if (is_xtal(cfg)) begin ph = 2; rem = OC; end
         else ph = 4;
      1: if (tick) begin
           rem = rem - 1;
           if (rem == 0) begin
             if (is_xtal(cfg)) begin ph = 2; rem = OC; end else ph = 4;
           end
         end
      2: begin rem = rem - 1; if (rem == 0) ph = 4; end
      3: if (is_xtal(cfg)) begin ph = 2; rem = OC; end else ph = 4;
      default: ;
    endcase
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string t;
    case (ph)
      0: t = "R1 reset";
      1: t = "R3 power-up delay";
      2: t = "R4 start-up count";
      3: t = "R5 master clear";
      default: t = cfg[7] ? "R2 R5 run" : "R6 pin ignored";
    endcase
    chk(t, core_rst, ph != 4);
    chk("R7 osc decode", {xt, int_rc, ext_rc, oerr}, {exp_osc(cfg)[8:4], exp_osc(cfg)[2]});
    chk("R8 clkout", clkout, exp_osc(cfg)[3]);
    chk("R9 protection", {mism, prot}, exp_prot(cfg));
    chk("R10 watchdog", wdt_en, cfg[3]);
  endtask

  task automatic step(bit t, bit m);
    @(negedge clk);
    check_all();
    tick = t;
    mclr_n = m;
  endtask

  task automatic run_cfg(logic [13:0] c, int cyc, int tprob, int mprob);
    @(negedge clk);
    por = 1; cfg = c; mclr_n = 1; tick = 0;
    step(0, 1);
    step(0, 1);
    por = 0;
    for (int i = 0; i < cyc; i++) begin
      bit m = 1;
      if (mprob != 0 && ($urandom % mprob) == 0) m = 0;
      step(($urandom % tprob) == 0, m);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    por = 1; mclr_n = 1; tick = 0; cfg = 14'h3fff;
    repeat (3) @(negedge clk);
    chk("R1 reset state", core_rst, 1);
    // directed corners
    run_cfg(14'h3fff, 20, 2, 0);          // ext RC, no delay, pin enabled
    run_cfg(14'h0000, 120, 3, 0);         // LP, delay on, all protected, pin off
    run_cfg(14'h3fe3, 40, 2, 0);          // invalid code, delay on
    run_cfg(14'h3ffa, 60, 2, 0);          // HS, no delay
    run_cfg(14'h2f5d, 30, 2, 0);          // mismatched pairs, int RC clkout
    run_cfg(14'h00a1, 120, 2, 4);         // XT, pin enabled, frequent pin pulses
    run_cfg(14'h0021, 120, 2, 3);         // XT, pin disabled, pin toggling (R6)
    for (int k = 0; k < 60; k++) begin
      logic [13:0] c = 14'($urandom);
      if ($urandom % 2) begin
        logic [1:0] p = 2'($urandom);
        c[13:12] = p; c[11:10] = p; c[9:8] = p; c[6:5] = p;
      end
      run_cfg(c, 60 + ($urandom % 60), 1 + ($urandom % 4), ($urandom % 2) ? 0 : 20);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule